// File: doc/BRIEF.md
# Bulk Endpoint Handshake Response Selector

This block picks the reply that a bulk or interrupt device endpoint sends back for each incoming token. A token decoder upstream presents a token type together with a strobe. The endpoint's current status arrives on the same cycle: halted, primed with a descriptor, transmit FIFO run dry, receive FIFO full, and whether the active descriptor still expects more packets. One registered cycle later the block emits a single encoded action. The packet engine then carries out that action: stay silent, send a handshake, start transmitting, accept data, or corrupt the outgoing packet on purpose.

The status flags are resolved in a fixed priority. A halt overrides everything. An unprimed endpoint comes next. A FIFO fault only counts when it matches the token's direction. A primed endpoint with no fault then follows the normal data path. Token decoding, CRC checking and data movement stay outside this block.

Top module: `bulk_ep_rsp`

## Requirements
- R1: Token codes are SETUP=0, IN=1, OUT=2, PING=3, and codes 4 to 7 are invalid. Action codes are IGNORE=0, STALL=1, NAK=2, ACK=3, TRANSMIT=4, RECEIVE_NYET=5, RECEIVE_ACK=6, BITSTUFF_ERR=7. `rsp_valid` is high for exactly the one cycle after each cycle where `tok_valid` is high. `rsp_action` reads 0 whenever `rsp_valid` is low.
- R2: When `ep_stall` is high, IN, OUT and PING get STALL, whatever the other status inputs are.
- R3: When `ep_stall` is low and `ep_primed` is low, IN, OUT and PING get NAK, whatever the FIFO flags and `pkts_left` are.
- R4: A SETUP token gets IGNORE under every combination of status inputs.
- R5: An invalid token (codes 4 to 7) gets IGNORE under every combination of status inputs.
- R6: On a primed, non-stalled endpoint, IN without `tx_underrun` gets TRANSMIT, and PING gets ACK whatever the FIFO flags are.
- R7: On a primed, non-stalled endpoint, IN with `tx_underrun` high gets BITSTUFF_ERR.
- R8: On a primed, non-stalled endpoint, OUT with `rx_overrun` high gets NAK.
- R9: On a primed, non-stalled endpoint, OUT without `rx_overrun` gets RECEIVE_ACK when `pkts_left` is high and RECEIVE_NYET when it is low.
- R10: `tx_underrun` has no effect on the reply to OUT, and `rx_overrun` has no effect on the reply to IN.
- R11: While `rst_n` is low, and in the first cycle after it rises, `rsp_valid` is 0 and `rsp_action` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_valid | input | 1 | Token strobe, one cycle per token |
| tok_type | input | 3 | Token code (see R1) |
| ep_stall | input | 1 | Endpoint halted |
| ep_primed | input | 1 | Endpoint has an active descriptor |
| tx_underrun | input | 1 | Transmit FIFO cannot supply data |
| rx_overrun | input | 1 | Receive FIFO cannot accept data |
| pkts_left | input | 1 | Active descriptor expects more packets |
| rsp_valid | output | 1 | Response strobe, one cycle after the token |
| rsp_action | output | 3 | Encoded action (see R1) |

## Verification
The halt check and the FIFO fault check can both be true for the same token. For example, an IN can arrive while the endpoint is stalled and its transmit FIFO is empty, or an OUT can arrive while the endpoint is unprimed and the receive FIFO is full. The bench provokes every such collision by sweeping all 32 status combinations under every token code. Tokens are sent back to back, so a response leaves while the next token is being captured. A reference model built from the requirements scores each response, so the winning rule must be the higher-priority one: STALL over NAK over the fault reply over the normal data reply.

// File: rtl/bulk_ep_rsp_pkg.sv
package bulk_ep_rsp_pkg;

    localparam int TOK_W = 3;
    localparam int ACT_W = 3;

    localparam logic [TOK_W-1:0] TOK_SETUP = 3'd0;
    localparam logic [TOK_W-1:0] TOK_IN    = 3'd1;
    localparam logic [TOK_W-1:0] TOK_OUT   = 3'd2;
    localparam logic [TOK_W-1:0] TOK_PING  = 3'd3;

    typedef enum logic [ACT_W-1:0] {
        ACT_IGNORE   = 3'd0,
        ACT_STALL    = 3'd1,
        ACT_NAK      = 3'd2,
        ACT_ACK      = 3'd3,
        ACT_TRANSMIT = 3'd4,
        ACT_RX_NYET  = 3'd5,
        ACT_RX_ACK   = 3'd6,
        ACT_BS_ERR   = 3'd7
    } rsp_act_e;

    typedef enum logic [1:0] {
        CL_HALT  = 2'd0,
        CL_IDLE  = 2'd1,
        CL_READY = 2'd2
    } ep_class_e;

    typedef struct packed {
        logic     valid;
        rsp_act_e act;
    } rsp_s;

endpackage

// File: rtl/epr_class.sv
module epr_class
    import bulk_ep_rsp_pkg::*;
(
    input  logic [TOK_W-1:0] tok_type,
    input  logic             ep_stall,
    input  logic             ep_primed,
    input  logic             tx_underrun,
    input  logic             rx_overrun,
    output ep_class_e        cls,
    output logic             fault
);

    always_comb begin
        if (ep_stall) begin
            cls = CL_HALT;
        end else if (!ep_primed) begin
            cls = CL_IDLE;
        end else begin
            cls = CL_READY;
        end
    end

    // a FIFO fault only counts for the direction the token moves data
    always_comb begin
        unique case (tok_type)
            TOK_IN:  fault = tx_underrun;
            TOK_OUT: fault = rx_overrun;
            default: fault = 1'b0;
        endcase
    end

endmodule

// File: rtl/epr_table.sv
module epr_table
    import bulk_ep_rsp_pkg::*;
(
    input  logic [TOK_W-1:0] tok_type,
    input  ep_class_e        cls,
    input  logic             fault,
    input  logic             pkts_left,
    output rsp_act_e         act
);

    logic data_tok;

    always_comb begin
        data_tok = (tok_type == TOK_IN) || (tok_type == TOK_OUT) || (tok_type == TOK_PING);
        act      = ACT_IGNORE;
        if (data_tok) begin
            unique case (cls)
                CL_HALT: act = ACT_STALL;
                CL_IDLE: act = ACT_NAK;
                default: begin
                    unique case (tok_type)
                        TOK_IN:  act = fault ? ACT_BS_ERR : ACT_TRANSMIT;
                        TOK_OUT: act = fault ? ACT_NAK
                                             : (pkts_left ? ACT_RX_ACK : ACT_RX_NYET);
                        default: act = ACT_ACK;
                    endcase
                end
            endcase
        end
    end

endmodule

// File: rtl/bulk_ep_rsp.sv
module bulk_ep_rsp
    import bulk_ep_rsp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok_valid,
    input  logic [TOK_W-1:0] tok_type,
    input  logic             ep_stall,
    input  logic             ep_primed,
    input  logic             tx_underrun,
    input  logic             rx_overrun,
    input  logic             pkts_left,
    output logic             rsp_valid,
    output logic [ACT_W-1:0] rsp_action
);

    ep_class_e cls;
    logic      fault;
    rsp_act_e  tbl_act;
    rsp_s      rsp_d, rsp_q;

    epr_class u_class (
        .tok_type   (tok_type),
        .ep_stall   (ep_stall),
        .ep_primed  (ep_primed),
        .tx_underrun(tx_underrun),
        .rx_overrun (rx_overrun),
        .cls        (cls),
        .fault      (fault)
    );

    epr_table u_table (
        .tok_type (tok_type),
        .cls      (cls),
        .fault    (fault),
        .pkts_left(pkts_left),
        .act      (tbl_act)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = tok_valid;
        rsp_d.act   = tok_valid ? tbl_act : ACT_IGNORE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid  = rsp_q.valid;
    assign rsp_action = rsp_q.act;

    AST_RSP_FOLLOWS_TOK: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid |=> rsp_valid); // R1
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !tok_valid |=> !rsp_valid); // R1
    AST_IDLE_ACTION_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> rsp_action == ACT_IGNORE); // R1
    AST_HALT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && ep_stall && (tok_type == TOK_IN || tok_type == TOK_OUT || tok_type == TOK_PING))
        |=> rsp_action == ACT_STALL); // R2
    AST_SETUP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_type == TOK_SETUP) |=> rsp_action == ACT_IGNORE); // R4
    AST_UNDERRUN_BS: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && !ep_stall && ep_primed && tx_underrun && tok_type == TOK_IN)
        |=> rsp_action == ACT_BS_ERR); // R7

endmodule

// File: tb/sim_bulk_ep_rsp.sv
module sim_bulk_ep_rsp;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tok_valid = 1'b0;
    logic [2:0] tok_type = 3'd0;
    logic       ep_stall = 1'b0, ep_primed = 1'b0, tx_underrun = 1'b0;
    logic       rx_overrun = 1'b0, pkts_left = 1'b0;
    logic       rsp_valid;
    logic [2:0] rsp_action;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [2:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    bulk_ep_rsp u0 (
        .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_type(tok_type),
        .ep_stall(ep_stall), .ep_primed(ep_primed), .tx_underrun(tx_underrun),
        .rx_overrun(rx_overrun), .pkts_left(pkts_left),
        .rsp_valid(rsp_valid), .rsp_action(rsp_action)
    );

    // reference model from the requirements
    function automatic logic [2:0] model(input logic [2:0] t, input logic st, input logic pr,
                                         input logic ur, input logic ov, input logic pl,
                                         output string tag);
        if (t == 3'd0) begin tag = "R4"; return 3'd0; end
        if (t > 3'd3)  begin tag = "R5"; return 3'd0; end
        if (st)        begin tag = "R2"; return 3'd1; end
        if (!pr)       begin tag = "R3"; return 3'd2; end
        if (t == 3'd3) begin tag = "R6"; return 3'd3; end
        if (t == 3'd1) begin
            if (ur) begin tag = "R7"; return 3'd7; end
            tag = ov ? "R10" : "R6";
            return 3'd4;
        end
        if (ov) begin tag = "R8"; return 3'd2; end
        tag = ur ? "R10" : "R9";
        return pl ? 3'd6 : 3'd5;
    endfunction

    task automatic send(input logic [2:0] t, input logic [4:0] f);
        string tg;
        logic [2:0] e;
        @(negedge clk);
        tok_valid = 1'b1; tok_type = t;
        {ep_stall, ep_primed, tx_underrun, rx_overrun, pkts_left} = f;
        e = model(t, f[4], f[3], f[2], f[1], f[0], tg);
        exp_q.push_back(e);
        tag_q.push_back(tg);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tok_valid = 1'b0;
            {ep_stall, ep_primed, tx_underrun, rx_overrun, pkts_left} = 5'b11111;
        end
    endtask

    // monitor: sample just after the active edge
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            if (exp_q.size() > 0) begin
                logic [2:0] e;
                string tg;
                e = exp_q.pop_front();
                tg = tag_q.pop_front();
                n_run++;
                if (!rsp_valid || rsp_action !== e) begin
                    n_fail++;
                    $display("FAIL %s/R1: valid=%0b action=%0d expected valid=1 action=%0d",
                             tg, rsp_valid, rsp_action, e);
                end
            end else if (rsp_valid !== 1'b0 || rsp_action !== 3'd0) begin
                n_run++;
                n_fail++;
                $display("FAIL R1: idle valid=%0b action=%0d expected valid=0 action=0",
                         rsp_valid, rsp_action);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        n_run++;
        if (rsp_valid !== 1'b0 || rsp_action !== 3'd0) begin
            n_fail++;
            $display("FAIL R11: in reset valid=%0b action=%0d expected 0/0", rsp_valid, rsp_action);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_run++;
        if (rsp_valid !== 1'b0 || rsp_action !== 3'd0) begin
            n_fail++;
            $display("FAIL R11: after reset valid=%0b action=%0d expected 0/0", rsp_valid, rsp_action);
        end
        // directed corners with gaps
        send(3'd1, 5'b11100); idle(1);  // R2 stall beats underrun
        send(3'd2, 5'b00011); idle(1);  // R3 unprimed beats overrun
        send(3'd1, 5'b01100); idle(2);  // R7
        send(3'd2, 5'b01010); idle(1);  // R8
        send(3'd2, 5'b01001); idle(1);  // R9 ack
        send(3'd2, 5'b01000); idle(1);  // R9 nyet
        send(3'd3, 5'b01110); idle(1);  // R6 ping
        send(3'd2, 5'b01101); idle(1);  // R10
        send(3'd6, 5'b01000); idle(1);  // R5
        send(3'd0, 5'b11111); idle(3);  // R4
        // exhaustive back-to-back sweep
        for (int t = 0; t < 8; t++) begin
            for (int f = 0; f < 32; f++) begin
                send(t[2:0], f[4:0]);
            end
        end
        idle(4);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule